// File: doc/BRIEF.md
# Read-While-Write Bank Access Guard

This block sits in front of a sixteen-bank flash array and holds the state of the one embedded program or erase that may run at a time. It records which bank the operation occupies and, for a sector erase, which sector. It also records whether that erase has been suspended. Read and program requests arrive on a valid/ready stream. For each accepted request the block returns one response that either grants the access or refuses it. A refused read is answered with device status in place of array data.

Conflicts are judged per bank while an operation runs: other banks stay readable with no extra delay. A suspended sector erase gives its bank back, apart from the one sector it is still erasing. A whole-device erase occupies all sixteen banks.

Request stream rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is pending, or when the pending response is being taken in the same cycle. The response appears in `rsp_valid`/`rsp_grant`/`rsp_status` on the edge after acceptance. It holds steady until `rsp_ready` is high. The decision uses the operation state as it stood before the accepting edge.

Top module: `rww_bank_guard`

## Requirements
- R1: With word address bits [24:0], the bank is bits [24:21] and a 64 Kword sector is bits [24:16]. Where bits [24:16] are all zero (bottom of bank 0) or all one (top of bank 15), sectors are 16 Kword and are selected by bits [24:14].
- R2: With no operation active, every request is answered with `rsp_grant`=1 and `rsp_status`=0.
- R3: While an operation runs unsuspended, a read to any bank not marked in `busy_map` is granted.
- R4: While an operation runs unsuspended, a read to a bank marked in `busy_map` is answered with `rsp_grant`=0 and `rsp_status`=1.
- R5: While an operation runs unsuspended, every program request is refused with `rsp_grant`=0 and `rsp_status`=0.
- R6: While a sector erase is suspended, reads and programs to any address outside the erased sector are granted. A request to that sector is refused, and `rsp_status` is 1 for a read and 0 for a program.
- R7: A suspended erase of a boot sector blocks only that 16 Kword sector. Its neighbouring boot sectors in the same 64 Kword range stay open.
- R8: `op_kind` 0 starts a program, 1 a sector erase, and 2 or 3 a whole-device erase. A whole-device erase sets all 16 bits of `busy_map`. `erase_suspend` is ignored for a program or whole-device erase, and `suspended` stays 0.
- R9: `op_start` while an operation is active or suspended raises `start_err` for one cycle on the next edge and leaves `busy`, `suspended` and `busy_map` unchanged.
- R10: `erase_resume` during a suspend returns the bank to fully busy (R4 and R5 apply again). `op_done` clears `busy`, `suspended` and `busy_map` on the next edge and takes priority over any other event in the same cycle.
- R11: `req_ready` = !`rsp_valid` || `rsp_ready`. A response appears one edge after acceptance and holds stable while `rsp_valid` is 1 and `rsp_ready` is 0.
- R12: After reset, `busy`, `suspended`, `busy_map`, `start_err` and `rsp_valid` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Pulse: an embedded operation begins |
| op_kind | input | 2 | 0 program, 1 sector erase, 2/3 whole-device erase |
| op_addr | input | 25 | Word address targeted by the operation |
| op_done | input | 1 | Pulse: the running operation has finished |
| erase_suspend | input | 1 | Pulse: suspend the running sector erase |
| erase_resume | input | 1 | Pulse: resume the suspended erase |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 25 | Word address of the request |
| req_is_prog | input | 1 | 1 = program request, 0 = read request |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_grant | output | 1 | Access may proceed now |
| rsp_status | output | 1 | Read answered with status instead of data |
| busy | output | 1 | An operation is active or suspended |
| suspended | output | 1 | The sector erase is suspended |
| busy_map | output | 16 | One bit per bank occupied by the operation |
| start_err | output | 1 | One-cycle flag: start refused while busy |

## Verification
Each request result is due on the clock edge after the one that accepts it. Each change of operation state (`busy`, `suspended`, `busy_map`, `start_err`) is due on the edge after the event pulse. The bench drives every stimulus at a falling edge and reads the outputs at the next falling edge, exactly one rising edge later. It predicts each value with a model updated at the same point. The back-pressure case holds a response for two cycles, then releases it in the same cycle that a waiting request is taken. This shows that the later decision sees the state as it was at that later edge.

// File: rtl/rww_pkg.sv
package rww_pkg;
  typedef enum logic [1:0] {
    OPK_PROG       = 2'd0,
    OPK_ERASE_SECT = 2'd1,
    OPK_ERASE_DEV  = 2'd2,
    OPK_ERASE_DEV2 = 2'd3
  } opk_e;

  localparam int unsigned ADDR_W_DEF = 25;
  localparam int unsigned BANK_W_DEF = 4;
  localparam int unsigned SECT_W_DEF = 16;
  localparam int unsigned BOOT_W_DEF = 14;
endpackage

// File: rtl/rww_addr_decode.sv
module rww_addr_decode #(
  parameter int unsigned ADDR_W = rww_pkg::ADDR_W_DEF,
  parameter int unsigned BANK_W = rww_pkg::BANK_W_DEF,
  parameter int unsigned SECT_W = rww_pkg::SECT_W_DEF,
  parameter int unsigned BOOT_W = rww_pkg::BOOT_W_DEF
) (
  input  logic [ADDR_W-BOOT_W-1:0] hi,
  output logic [BANK_W-1:0]        bank,
  output logic [ADDR_W-BOOT_W-1:0] key
);
  localparam int unsigned KEY_W = ADDR_W - BOOT_W;
  localparam int unsigned SUB_W = SECT_W - BOOT_W;
  localparam int unsigned BLK_W = ADDR_W - SECT_W;

  logic [BLK_W-1:0] blk;
  logic             in_boot;

  assign blk     = hi[KEY_W-1:SUB_W];
  assign bank    = hi[KEY_W-1:KEY_W-BANK_W];
  // boot regions: lowest 64K block of the array and highest one
  assign in_boot = (blk == '0) || (blk == '1);
  assign key     = in_boot ? hi : {blk, {SUB_W{1'b0}}};
endmodule

// File: rtl/rww_busy_tracker.sv
module rww_busy_tracker #(
  parameter int unsigned BANK_W = rww_pkg::BANK_W_DEF,
  parameter int unsigned KEY_W  = rww_pkg::ADDR_W_DEF - rww_pkg::BOOT_W_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_start,
  input  logic [1:0]           op_kind,
  input  logic [BANK_W-1:0]    op_bank,
  input  logic [KEY_W-1:0]     op_key,
  input  logic                 op_done,
  input  logic                 erase_suspend,
  input  logic                 erase_resume,
  output logic                 busy,
  output logic                 suspended,
  output logic [(1<<BANK_W)-1:0] busy_map,
  output logic                 start_err,
  output logic [KEY_W-1:0]     hold_key
);
  import rww_pkg::*;
  localparam int unsigned NBANK = 1 << BANK_W;

  logic              busy_q, susp_q, dev_q, erase_q, err_q;
  logic [BANK_W-1:0] bank_q;
  logic [KEY_W-1:0]  key_q;
  opk_e              kind;

  assign kind = opk_e'(op_kind);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      susp_q  <= 1'b0;
      dev_q   <= 1'b0;
      erase_q <= 1'b0;
      err_q   <= 1'b0;
      bank_q  <= '0;
      key_q   <= '0;
    end else begin
      err_q <= op_start && busy_q;
      if (op_done) begin
        busy_q <= 1'b0;
        susp_q <= 1'b0;
        dev_q  <= 1'b0;
        erase_q <= 1'b0;
      end else if (op_start && !busy_q) begin
        busy_q  <= 1'b1;
        susp_q  <= 1'b0;
        dev_q   <= (kind == OPK_ERASE_DEV) || (kind == OPK_ERASE_DEV2);
        erase_q <= (kind != OPK_PROG);
        bank_q  <= op_bank;
        key_q   <= op_key;
      end else if (erase_suspend && busy_q && erase_q && !dev_q && !susp_q) begin
        susp_q <= 1'b1;
      end else if (erase_resume && susp_q) begin
        susp_q <= 1'b0;
      end
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_map
    assign busy_map[b] = busy_q && (dev_q || (bank_q == BANK_W'(b)));
  end

  assign busy      = busy_q;
  assign suspended = susp_q;
  assign start_err = err_q;
  assign hold_key  = key_q;

  assert_start_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && busy && !op_done) |=> (start_err && busy && $stable(busy_map)));
  assert_done_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> (!busy && !suspended && busy_map == '0));
  assert_resume_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && erase_resume && !op_done) |=> (busy && !suspended));
  assert_dev_no_suspend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dev_q) |-> (!suspended && (&busy_map)));
endmodule

// File: rtl/rww_access_judge.sv
module rww_access_judge #(
  parameter int unsigned BANK_W = rww_pkg::BANK_W_DEF,
  parameter int unsigned KEY_W  = rww_pkg::ADDR_W_DEF - rww_pkg::BOOT_W_DEF
) (
  input  logic                   busy,
  input  logic                   suspended,
  input  logic [(1<<BANK_W)-1:0] busy_map,
  input  logic [KEY_W-1:0]       hold_key,
  input  logic [BANK_W-1:0]      req_bank,
  input  logic [KEY_W-1:0]       req_key,
  input  logic                   req_is_prog,
  output logic                   grant,
  output logic                   status
);
  always_comb begin
    grant  = 1'b1;
    status = 1'b0;
    if (busy && !suspended) begin
      if (req_is_prog) begin
        grant = 1'b0;
      end else if (busy_map[req_bank]) begin
        grant  = 1'b0;
        status = 1'b1;
      end
    end else if (suspended && (req_key == hold_key)) begin
      grant  = 1'b0;
      status = !req_is_prog;
    end
  end
endmodule

// File: rtl/rww_bank_guard.sv
module rww_bank_guard #(
  parameter int unsigned ADDR_W = rww_pkg::ADDR_W_DEF,
  parameter int unsigned BANK_W = rww_pkg::BANK_W_DEF,
  parameter int unsigned SECT_W = rww_pkg::SECT_W_DEF,
  parameter int unsigned BOOT_W = rww_pkg::BOOT_W_DEF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_start,
  input  logic [1:0]             op_kind,
  input  logic [ADDR_W-1:0]      op_addr,
  input  logic                   op_done,
  input  logic                   erase_suspend,
  input  logic                   erase_resume,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic                   req_is_prog,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic                   rsp_grant,
  output logic                   rsp_status,
  output logic                   busy,
  output logic                   suspended,
  output logic [(1<<BANK_W)-1:0] busy_map,
  output logic                   start_err
);
  localparam int unsigned KEY_W = ADDR_W - BOOT_W;

  logic [BANK_W-1:0] op_bank, req_bank;
  logic [KEY_W-1:0]  op_key, req_key, hold_key;
  logic              dec_grant, dec_status;
  logic              rsp_v_q, rsp_g_q, rsp_s_q;
  logic              take;
  logic              unused_low_bits;

  assign unused_low_bits = ^{op_addr[BOOT_W-1:0], req_addr[BOOT_W-1:0]};

  rww_addr_decode #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .SECT_W(SECT_W), .BOOT_W(BOOT_W))
    u_op_dec (.hi(op_addr[ADDR_W-1:BOOT_W]), .bank(op_bank), .key(op_key));

  rww_addr_decode #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .SECT_W(SECT_W), .BOOT_W(BOOT_W))
    u_req_dec (.hi(req_addr[ADDR_W-1:BOOT_W]), .bank(req_bank), .key(req_key));

  rww_busy_tracker #(.BANK_W(BANK_W), .KEY_W(KEY_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .op_start(op_start), .op_kind(op_kind), .op_bank(op_bank), .op_key(op_key),
    .op_done(op_done), .erase_suspend(erase_suspend), .erase_resume(erase_resume),
    .busy(busy), .suspended(suspended), .busy_map(busy_map),
    .start_err(start_err), .hold_key(hold_key)
  );

  rww_access_judge #(.BANK_W(BANK_W), .KEY_W(KEY_W)) u_judge (
    .busy(busy), .suspended(suspended), .busy_map(busy_map), .hold_key(hold_key),
    .req_bank(req_bank), .req_key(req_key), .req_is_prog(req_is_prog),
    .grant(dec_grant), .status(dec_status)
  );

  assign req_ready = !rsp_v_q || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_g_q <= 1'b0;
      rsp_s_q <= 1'b0;
    end else if (take) begin
      rsp_v_q <= 1'b1;
      rsp_g_q <= dec_grant;
      rsp_s_q <= dec_status;
    end else if (rsp_ready) begin
      rsp_v_q <= 1'b0;
    end
  end

  assign rsp_valid  = rsp_v_q;
  assign rsp_grant  = rsp_g_q;
  assign rsp_status = rsp_s_q;

  assert_idle_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !busy) |=> (rsp_valid && rsp_grant && !rsp_status));
  assert_busy_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_is_prog && busy && !suspended && busy_map[req_bank])
      |=> (rsp_valid && !rsp_grant && rsp_status));
  assert_prog_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_is_prog && busy && !suspended) |=> (rsp_valid && !rsp_grant && !rsp_status));
  assert_other_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_is_prog && busy && !suspended && !busy_map[req_bank]) |=> rsp_grant);
  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_grant) && $stable(rsp_status)));
endmodule

// File: tb/rww_bank_guard_tb.sv
module rww_bank_guard_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_start = 0, op_done = 0, erase_suspend = 0, erase_resume = 0;
  logic [1:0]  op_kind = 0;
  logic [24:0] op_addr = 0, req_addr = 0;
  logic        req_valid = 0, req_is_prog = 0, rsp_ready = 1;
  logic        req_ready, rsp_valid, rsp_grant, rsp_status, busy, suspended, start_err;
  logic [15:0] busy_map;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model of the operation state
  bit          m_busy, m_susp, m_dev, m_erase;
  logic [3:0]  m_bank;
  logic [10:0] m_key;
  logic [24:0] m_addr;

  always #(CLK_P/2) clk = ~clk;

  rww_bank_guard dut_i (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr),
    .op_done(op_done), .erase_suspend(erase_suspend), .erase_resume(erase_resume),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_is_prog(req_is_prog), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_grant(rsp_grant), .rsp_status(rsp_status), .busy(busy), .suspended(suspended),
    .busy_map(busy_map), .start_err(start_err)
  );

  function automatic logic [3:0] f_bank(logic [24:0] a);
    return a[24:21];
  endfunction

  function automatic logic [10:0] f_key(logic [24:0] a);
    if (a[24:16] == 9'h000 || a[24:16] == 9'h1ff) return a[24:14];
    return {a[24:16], 2'b00};
  endfunction

  function automatic logic [15:0] f_map();
    if (!m_busy) return 16'h0;
    if (m_dev) return 16'hffff;
    return 16'h1 << m_bank;
  endfunction

  // returns {grant, status}
  function automatic logic [1:0] f_decide(logic [24:0] a, logic prog);
    if (!m_busy) return 2'b10;
    if (!m_susp) begin
      if (prog) return 2'b00;
      if (f_map()[f_bank(a)]) return 2'b01;
      return 2'b10;
    end
    if (f_key(a) == m_key) return {1'b0, !prog};
    return 2'b10;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    check({tag, " busy"}, 32'(busy), 32'(m_busy));
    check({tag, " suspended"}, 32'(suspended), 32'(m_susp));
    check({tag, " busy_map"}, 32'(busy_map), 32'(f_map()));
  endtask

  task automatic do_req(input logic [24:0] a, input logic prog, input string tag);
    logic [1:0] e;
    e = f_decide(a, prog);
    req_addr = a; req_is_prog = prog; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    check({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " grant/status"}, {30'd0, rsp_grant, rsp_status}, {30'd0, e});
  endtask

  task automatic do_start(input logic [1:0] k, input logic [24:0] a, input string tag);
    bit exp_err;
    exp_err = m_busy;
    op_start = 1; op_kind = k; op_addr = a;
    @(negedge clk);
    op_start = 0;
    if (!m_busy) begin
      m_busy = 1; m_susp = 0; m_dev = k[1]; m_erase = (k != 2'd0);
      m_bank = f_bank(a); m_key = f_key(a); m_addr = a;
    end
    check({tag, " start_err"}, 32'(start_err), 32'(exp_err));
    chk_state(tag);
  endtask

  task automatic do_done(input string tag);
    op_done = 1;
    @(negedge clk);
    op_done = 0;
    m_busy = 0; m_susp = 0; m_dev = 0; m_erase = 0;
    chk_state(tag);
  endtask

  task automatic do_susp(input string tag);
    erase_suspend = 1;
    @(negedge clk);
    erase_suspend = 0;
    if (m_busy && m_erase && !m_dev && !m_susp) m_susp = 1;
    chk_state(tag);
  endtask

  task automatic do_resume(input string tag);
    erase_resume = 1;
    @(negedge clk);
    erase_resume = 0;
    if (m_susp) m_susp = 0;
    chk_state(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    check("R12 busy", 32'(busy), 0);
    check("R12 suspended", 32'(suspended), 0);
    check("R12 busy_map", 32'(busy_map), 0);
    check("R12 start_err", 32'(start_err), 0);
    check("R12 rsp_valid", 32'(rsp_valid), 0);
    check("R12 req_ready", 32'(req_ready), 1);

    // R2 idle grants
    do_req(25'h0A1_2345, 0, "R2 idle read");
    do_req(25'h1F0_0000, 1, "R2 idle program");

    // R3 R4 R5 program running in bank 5
    do_start(2'd0, {4'd5, 21'h01_2345}, "R8 start program");
    do_req({4'd5, 21'h1F_0000}, 0, "R4 read busy bank");
    do_req({4'd6, 21'h00_0000}, 0, "R3 read other bank");
    do_req({4'd6, 21'h00_0000}, 1, "R5 program other bank");
    do_susp("R8 suspend of program ignored");
    do_start(2'd1, {4'd2, 21'h0}, "R9 second start");
    do_done("R10 done after program");

    // R6 suspended sector erase in bank 3
    do_start(2'd1, {4'd3, 5'd7, 16'h1234}, "R6 start erase");
    do_req({4'd3, 5'd9, 16'h0}, 0, "R4 read erasing bank");
    do_susp("R6 suspend");
    do_req({4'd3, 5'd7, 16'hFFFF}, 0, "R6 read erased sector");
    do_req({4'd3, 5'd7, 16'h0000}, 1, "R6 program erased sector");
    do_req({4'd3, 5'd8, 16'h0000}, 0, "R6 read same bank other sector");
    do_req({4'd3, 5'd6, 16'hABCD}, 1, "R6 program same bank other sector");
    do_req({4'd9, 21'h0}, 1, "R6 program other bank");
    do_start(2'd0, {4'd9, 21'h0}, "R9 start while suspended");
    do_resume("R10 resume");
    do_req({4'd3, 5'd8, 16'h0000}, 0, "R10 read after resume");
    do_req({4'd3, 5'd8, 16'h0000}, 1, "R10 program after resume");
    do_done("R10 done after erase");

    // R7 boot sector in bank 0, second 16K
    do_start(2'd1, 25'h000_4000, "R7 start boot erase");
    do_susp("R7 suspend");
    do_req(25'h000_0010, 0, "R7 neighbour boot below");
    do_req(25'h000_5FFF, 0, "R7 erased boot sector");
    do_req(25'h000_8000, 1, "R7 neighbour boot above");
    do_req(25'h001_0000, 0, "R1 first 64K sector of bank 0");
    do_done("R7 done");
    // top boot region of bank 15
    do_start(2'd1, 25'h1FF_C001, "R1 start top boot erase");
    do_susp("R1 suspend top");
    do_req(25'h1FF_8000, 0, "R1 boot below top");
    do_req(25'h1FF_FFFF, 0, "R1 top boot sector");
    do_req(25'h1FE_FFFF, 1, "R1 64K sector of bank 15");
    do_done("R1 done");
    // ordinary 64K sector spans all four 16K parts
    do_start(2'd1, {4'd4, 5'd3, 16'h0000}, "R1 start 64K erase");
    do_susp("R1 suspend 64K");
    do_req({4'd4, 5'd3, 16'hC000}, 0, "R1 same 64K sector high part");
    do_done("R1 done 64K");

    // R8 whole-device erase
    do_start(2'd3, 25'h0, "R8 device erase");
    do_req({4'd12, 21'h0}, 0, "R8 read any bank");
    do_susp("R8 suspend ignored");
    do_req({4'd0, 21'h0}, 1, "R8 program refused");
    do_done("R8 done");

    // R11 back-pressure
    rsp_ready = 0;
    req_addr = {4'd2, 21'h0}; req_is_prog = 0; req_valid = 1;
    @(negedge clk);
    check("R11 rsp_valid", 32'(rsp_valid), 1);
    check("R11 first grant", {30'd0, rsp_grant, rsp_status}, 32'b10);
    check("R11 ready low", 32'(req_ready), 0);
    op_start = 1; op_kind = 2'd0; op_addr = {4'd2, 21'h100};
    @(negedge clk);
    op_start = 0;
    m_busy = 1; m_susp = 0; m_dev = 0; m_erase = 0; m_bank = 4'd2;
    m_key = f_key({4'd2, 21'h100}); m_addr = {4'd2, 21'h100};
    check("R11 held grant", {30'd0, rsp_grant, rsp_status}, 32'b10);
    check("R11 held valid", 32'(rsp_valid), 1);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    check("R11 second rsp valid", 32'(rsp_valid), 1);
    check("R11 second rsp", {30'd0, rsp_grant, rsp_status}, 32'b01);
    @(negedge clk);
    check("R11 drained", 32'(rsp_valid), 0);
    do_done("R11 done");

    // constrained random
    for (int i = 0; i < 600; i++) begin
      int r;
      logic [24:0] a;
      r = $urandom % 12;
      a = 25'($urandom);
      if (m_busy && ($urandom % 2 == 1)) begin
        a = {m_addr[24:16], 16'($urandom)};
        if ($urandom % 3 == 0) a[20:16] = 5'($urandom);
      end
      if ($urandom % 8 == 0) a[24:16] = ($urandom % 2 == 1) ? 9'h1ff : 9'h000;
      case (r)
        0: do_start(2'($urandom), a, "R9 random start");
        1: if (m_busy) do_done("R10 random done"); else do_req(a, 0, "R2 random read");
        2: do_susp("R6 random suspend");
        3: do_resume("R10 random resume");
        default: do_req(a, 1'($urandom), "R6 random request");
      endcase
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule